// File: doc/BRIEF.md
# Multi-Domain Reset Sequencer with Access Gating

This block sequences the resets of a small multi-port device. An active-low chip reset pin puts every domain into reset: the digital core, and three PHY-like sub-modules that each have a reset output of their own. When the pin is released, the block holds the domains in reset for a fixed base time. During that time it also captures the configuration straps. It then starts an external configuration loader and waits for the loader to report that it has finished. Only after that does it raise its ready flag.

Software can request two smaller resets through a reset control register. A digital reset resets the core domain only and then runs the loader again, without capturing the straps. A single-PHY reset pulses the reset of one PHY and nothing else. Each request bit clears itself when its reset completes.

Until ready is set, the register port answers reads only for a short whitelist of addresses, and it drops every write. The loader paces its byte transfers on a tick that the block produces, so each byte it transfers lengthens the reset sequence by a fixed amount.

Top module: `rst_seq_top`

## Requirements
- R1: While `rst_n` is low, `core_rst_n`, every bit of `phy_rst_n` and `ready` are low. After `rst_n` rises, `core_rst_n` first reads high BASE_CYCLES+2 clock edges later. Two of those edges go to the release synchronizer. All PHY resets stay asserted for as long as the core reset does.
- R2: The strap inputs are captured only during the base phase of a pin reset. They are visible in bits STRAP_W-1:0 of the config register (address 1). A digital reset or a PHY reset leaves that field unchanged.
- R3: Writing 1 to bit 0 of the reset control register (address 2) while ready does three things. It drops `ready`. It holds `core_rst_n` low for exactly BASE_CYCLES cycles. It leaves every `phy_rst_n` bit high.
- R4: At the end of a base phase, `ldr_start` pulses for one cycle, in the same cycle that `core_rst_n` rises, unless `ldr_empty` is high. During the load, `ldr_tick` pulses every PER_BYTE_CYCLES cycles, the first one PER_BYTE_CYCLES-1 cycles after `ldr_start`.
- R5: `ready` rises one cycle after `ldr_done` is sampled high. When `ldr_empty` is high at the end of the base phase, `ready` rises in the same cycle as `core_rst_n`, and the loader is not started.
- R6: Writing 1 to bit k+1 of the reset control register while ready holds `phy_rst_n[k]` low for PHY_CYCLES cycles. Bit k+1 reads 1 while that reset runs and 0 once it is over. The core, the other PHYs, the loader and `ready` are unaffected.
- R7: Addresses 0, 1 and 2 can be read at any time. A read of any other address while `ready` is low returns 0 with `reg_rerr` high.
- R8: Every write is dropped while `ready` is low. This includes a repeated digital reset request made while a reset is in progress.
- R9: The register at address 3 keeps its value through a digital reset. The register at address 4 is cleared by a digital reset. A pin reset clears both.
- R10: Address 0 reads 0 during the base phase of a pin reset and 32'h1F2E3D4C at all other times.
- R11: Read data and `reg_rerr` arrive one cycle after `reg_rd`, qualified by `reg_rvalid`. In the config register, bit 31 is `ready`. In the reset control register, bit 0 reads 1 while any core reset sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset pin, active low, asynchronous assert |
| strap_in | input | STRAP_W | Configuration strap levels |
| ldr_empty | input | 1 | Loader has no bytes to transfer |
| ldr_done | input | 1 | Loader finished its transfer |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| core_rst_n | output | 1 | Core domain reset, active low |
| phy_rst_n | output | N_PHY | Per-PHY resets, active low |
| ready | output | 1 | Device ready flag |
| ldr_start | output | 1 | One-cycle loader start pulse |
| ldr_tick | output | 1 | Per-byte pacing tick during load |
| reg_rdata | output | 32 | Read data |
| reg_rerr | output | 1 | Gated read error |
| reg_rvalid | output | 1 | Read response valid |

## Verification
The bench builds the block with BASE_CYCLES=8, PER_BYTE_CYCLES=3 and PHY_CYCLES=5, with three PHYs and four straps. With these values, each pin, digital, PHY and empty-loader sequence completes in a few dozen cycles. The exact reset lengths, the tick spacing and the one-cycle gap from done to ready can therefore be counted edge by edge. The gated reads and dropped writes are checked during both the pin and the digital sequences. The straps are changed between resets to show when they are, and are not, captured.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    ST_PIN  = 2'd0,
    ST_DIG  = 2'd1,
    ST_LOAD = 2'd2,
    ST_RDY  = 2'd3
  } seq_state_e;

  localparam int unsigned ADDR_PROBE = 0;
  localparam int unsigned ADDR_CFG   = 1;
  localparam int unsigned ADDR_CTL   = 2;
  localparam int unsigned ADDR_KEEP  = 3;
  localparam int unsigned ADDR_SOFT  = 4;

  localparam logic [31:0] PROBE_WORD = 32'h1F2E_3D4C;
endpackage

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned BASE_CYCLES     = 38000,
  parameter int unsigned PER_BYTE_CYCLES = 4550
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dig_req,
  input  logic       ldr_empty,
  input  logic       ldr_done,
  output seq_state_e state_o,
  output logic       ldr_start,
  output logic       ldr_tick
);
  localparam int unsigned CNT_MAX = (BASE_CYCLES > PER_BYTE_CYCLES) ? BASE_CYCLES : PER_BYTE_CYCLES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'(BASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(PER_BYTE_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    case (state_q)
      ST_PIN, ST_DIG: begin
        if (cnt_q == BASE_LAST) begin
          cnt_d = '0;
          if (ldr_empty) begin
            state_d = ST_RDY;
          end else begin
            state_d = ST_LOAD;
            start_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_LOAD: begin
        if (ldr_done) begin
          state_d = ST_RDY;
          cnt_d   = '0;
        end else if (cnt_q == BYTE_LAST) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        cnt_d = '0;
        if (dig_req) state_d = ST_DIG;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PIN;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  assign state_o   = state_q;
  assign ldr_start = start_q;
  assign ldr_tick  = (state_q == ST_LOAD) && (cnt_q == BYTE_LAST);
endmodule

// File: rtl/rst_seq_phy_chan.sv
module rst_seq_phy_chan #(
  parameter int unsigned PHY_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(PHY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHY_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/rst_seq_regs.sv
module rst_seq_regs
  import rst_seq_pkg::*;
#(
  parameter int unsigned N_PHY   = 3,
  parameter int unsigned STRAP_W = 4,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready,
  input  logic               pin_phase,
  input  logic               dig_phase,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic [N_PHY-1:0]   phy_busy,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic               dig_req,
  output logic [N_PHY-1:0]   phy_req,
  output logic [31:0]        reg_rdata,
  output logic               reg_rerr,
  output logic               reg_rvalid,
  output logic [STRAP_W-1:0] strap_q,
  output logic [31:0]        keep_q
);
  logic        wr_ok, ctl_hit, keep_en, soft_en, whitelist, allowed;
  logic [31:0] soft_q, rd_word, cfg_word, ctl_word;
  logic [31:0] rdata_q;
  logic        rerr_q, rvalid_q;

  assign wr_ok     = reg_wr & ready;
  assign ctl_hit   = (reg_addr == ADDR_W'(ADDR_CTL));
  assign dig_req   = wr_ok & ctl_hit & reg_wdata[0];
  assign phy_req   = (wr_ok & ctl_hit) ? reg_wdata[N_PHY:1] : '0;
  assign keep_en   = wr_ok & (reg_addr == ADDR_W'(ADDR_KEEP));
  assign soft_en   = wr_ok & (reg_addr == ADDR_W'(ADDR_SOFT));
  assign whitelist = (reg_addr == ADDR_W'(ADDR_PROBE)) |
                     (reg_addr == ADDR_W'(ADDR_CFG)) | ctl_hit;
  assign allowed   = whitelist | ready;

  always_comb begin
    cfg_word = '0;
    cfg_word[STRAP_W-1:0] = strap_q;
    cfg_word[31] = ready;
    ctl_word = '0;
    ctl_word[0] = ~ready;
    ctl_word[N_PHY:1] = phy_busy;
    if (reg_addr == ADDR_W'(ADDR_PROBE))     rd_word = pin_phase ? 32'd0 : PROBE_WORD;
    else if (reg_addr == ADDR_W'(ADDR_CFG))  rd_word = cfg_word;
    else if (ctl_hit)                        rd_word = ctl_word;
    else if (reg_addr == ADDR_W'(ADDR_KEEP)) rd_word = keep_q;
    else if (reg_addr == ADDR_W'(ADDR_SOFT)) rd_word = soft_q;
    else                                     rd_word = '0;
  end

  // straps: loaded only in the pin base phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         strap_q <= '0;
    else if (pin_phase) strap_q <= strap_in;
  end

  // kept through digital reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       keep_q <= '0;
    else if (keep_en) keep_q <= reg_wdata;
  end

  // cleared by digital reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         soft_q <= '0;
    else if (dig_phase) soft_q <= '0;
    else if (soft_en)   soft_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rerr_q   <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      rerr_q   <= reg_rd & ~allowed;
      if (reg_rd) rdata_q <= allowed ? rd_word : 32'd0;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rerr   = rerr_q;
  assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned N_PHY           = 3,
  parameter int unsigned STRAP_W         = 4,
  parameter int unsigned ADDR_W          = 4,
  parameter int unsigned BASE_CYCLES     = 38000,
  parameter int unsigned PER_BYTE_CYCLES = 4550,
  parameter int unsigned PHY_CYCLES      = 2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic               ldr_empty,
  input  logic               ldr_done,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic               core_rst_n,
  output logic [N_PHY-1:0]   phy_rst_n,
  output logic               ready,
  output logic               ldr_start,
  output logic               ldr_tick,
  output logic [31:0]        reg_rdata,
  output logic               reg_rerr,
  output logic               reg_rvalid
);
  logic [1:0]         sync_q;
  logic               rst_sync_n;
  seq_state_e         state;
  logic               pin_phase, dig_phase, dig_req;
  logic [N_PHY-1:0]   phy_req, phy_busy;
  logic [STRAP_W-1:0] strap_q;
  logic [31:0]        keep_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  rst_seq_fsm #(
    .BASE_CYCLES    (BASE_CYCLES),
    .PER_BYTE_CYCLES(PER_BYTE_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .dig_req  (dig_req),
    .ldr_empty(ldr_empty),
    .ldr_done (ldr_done),
    .state_o  (state),
    .ldr_start(ldr_start),
    .ldr_tick (ldr_tick)
  );

  assign pin_phase  = (state == ST_PIN);
  assign dig_phase  = (state == ST_DIG);
  assign core_rst_n = ~(pin_phase | dig_phase);
  assign ready      = (state == ST_RDY);

  for (genvar k = 0; k < N_PHY; k++) begin : g_phy
    rst_seq_phy_chan #(.PHY_CYCLES(PHY_CYCLES)) u_chan (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .start(phy_req[k]),
      .busy (phy_busy[k])
    );
    assign phy_rst_n[k] = ~(phy_busy[k] | pin_phase);
  end

  rst_seq_regs #(
    .N_PHY  (N_PHY),
    .STRAP_W(STRAP_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ready     (ready),
    .pin_phase (pin_phase),
    .dig_phase (dig_phase),
    .strap_in  (strap_in),
    .phy_busy  (phy_busy),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dig_req   (dig_req),
    .phy_req   (phy_req),
    .reg_rdata (reg_rdata),
    .reg_rerr  (reg_rerr),
    .reg_rvalid(reg_rvalid),
    .strap_q   (strap_q),
    .keep_q    (keep_q)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int unsigned N_PHY   = 3,
  parameter int unsigned STRAP_W = 4,
  parameter int unsigned ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               pin_phase,
  input logic               core_rst_n,
  input logic [N_PHY-1:0]   phy_rst_n,
  input logic               ready,
  input logic               ldr_start,
  input logic               ldr_done,
  input logic               reg_rd,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_rdata,
  input logic               reg_rerr,
  input logic               reg_rvalid,
  input logic [STRAP_W-1:0] strap_q,
  input logic [31:0]        keep_q
);
  // R1
  pin_phy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pin_phase |-> (phy_rst_n == '0) && !core_rst_n);

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pin_phase |=> $stable(strap_q));

  // R3
  core_ready_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready |-> core_rst_n);

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ldr_start |=> !ldr_start);

  // R5
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ready) |-> ($past(ldr_done) || ($past(core_rst_n) == 1'b0)));

  // R7
  gated_rd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rd && !ready && (reg_addr > ADDR_W'(2))) |=> (reg_rerr && (reg_rdata == 32'd0)));

  // R8
  gated_wr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && !ready) |=> $stable(keep_q));

  // R11
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rd |=> reg_rvalid);
endmodule

bind rst_seq_top rst_seq_chk #(
  .N_PHY  (N_PHY),
  .STRAP_W(STRAP_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .pin_phase (pin_phase),
  .core_rst_n(core_rst_n),
  .phy_rst_n (phy_rst_n),
  .ready     (ready),
  .ldr_start (ldr_start),
  .ldr_done  (ldr_done),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .reg_rerr  (reg_rerr),
  .reg_rvalid(reg_rvalid),
  .strap_q   (strap_q),
  .keep_q    (keep_q)
);

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_PHY = 3;
  localparam int STRAP_W = 4;
  localparam int ADDR_W = 4;
  localparam int BASE = 8;
  localparam int PERB = 3;
  localparam int PHYC = 5;
  localparam logic [31:0] PROBE = 32'h1F2E_3D4C;

  logic clk = 1'b0;
  logic rst_n;
  logic [STRAP_W-1:0] strap_in;
  logic ldr_empty, ldr_done;
  logic reg_rd, reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0] reg_wdata;
  logic core_rst_n, ready, ldr_start, ldr_tick;
  logic [N_PHY-1:0] phy_rst_n;
  logic [31:0] reg_rdata;
  logic reg_rerr, reg_rvalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_seq_top #(
    .N_PHY(N_PHY), .STRAP_W(STRAP_W), .ADDR_W(ADDR_W),
    .BASE_CYCLES(BASE), .PER_BYTE_CYCLES(PERB), .PHY_CYCLES(PHYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .ldr_empty(ldr_empty),
    .ldr_done(ldr_done), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .core_rst_n(core_rst_n), .phy_rst_n(phy_rst_n),
    .ready(ready), .ldr_start(ldr_start), .ldr_tick(ldr_tick),
    .reg_rdata(reg_rdata), .reg_rerr(reg_rerr), .reg_rvalid(reg_rvalid)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  int ldr_nbytes = 1;
  int ldr_ticks = 0;
  bit ldr_busy = 0;
  int starts = 0;
  int start_cyc = -1, first_tick_cyc = -1, done_cyc = -1;
  int core_rise_cyc = -1, core_fall_cyc = -1, ready_cyc = -1;
  int phy_low[N_PHY];
  bit core_prev = 0, ready_prev = 0;
  logic [32:0] q_exp[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor, loader model and scoreboard, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    ldr_done = 1'b0;
    if (core_rst_n && !core_prev) core_rise_cyc = cyc;
    if (!core_rst_n && core_prev) core_fall_cyc = cyc;
    if (ready && !ready_prev) ready_cyc = cyc;
    core_prev = core_rst_n;
    ready_prev = ready;
    for (int k = 0; k < N_PHY; k++) if (rst_n && !phy_rst_n[k]) phy_low[k]++;
    if (ldr_busy && ldr_tick) begin
      ldr_ticks++;
      if (ldr_ticks == 1) first_tick_cyc = cyc;
      if (ldr_ticks == ldr_nbytes) begin
        ldr_done = 1'b1;
        ldr_busy = 0;
        done_cyc = cyc;
      end
    end
    if (ldr_start) begin
      ldr_busy = 1;
      ldr_ticks = 0;
      starts++;
      start_cyc = cyc;
    end
    if (reg_rvalid) begin
      if (q_exp.size() == 0) begin
        chk(0, "R11 unexpected response", reg_rdata, 32'd0);
      end else begin
        logic [32:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk({reg_rerr, reg_rdata} == e, t, reg_rdata, e[31:0]);
        chk(reg_rerr == e[32], {t, " err"}, {31'd0, reg_rerr}, {31'd0, e[32]});
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input bit err, input string tag);
    reg_rd = 1'b1;
    reg_addr = ADDR_W'(a);
    q_exp.push_back({err, exp});
    q_tag.push_back(tag);
    step();
    reg_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1;
    reg_addr = ADDR_W'(a);
    reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (!ready && n < 500) begin step(); n++; end
    chk(ready, tag, {31'd0, ready}, 32'd1);
  endtask

  task automatic clr_phy();
    for (int k = 0; k < N_PHY; k++) phy_low[k] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int c0, fall0, starts0;
    rst_n = 1'b0; strap_in = 4'hA; ldr_empty = 1'b0; ldr_done = 1'b0;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    ldr_nbytes = 4;
    repeat (3) step();
    // R1 reset state
    chk(core_rst_n == 0, "R1 core in reset", {31'd0, core_rst_n}, 32'd0);
    chk(phy_rst_n == '0, "R1 phys in reset", {29'd0, phy_rst_n}, 32'd0);
    chk(ready == 0, "R1 ready low", {31'd0, ready}, 32'd0);
    clr_phy();
    rst_n = 1'b1;
    c0 = cyc;
    repeat (3) step();
    rd(0, 32'd0, 0, "R10 probe during pin base");
    step();
    rd(1, 32'h0000_000A, 0, "R2 straps during pin base");
    while (!core_rst_n) step();
    chk(core_rise_cyc - c0 == BASE + 2, "R1 pin release length", core_rise_cyc - c0, BASE + 2);
    chk(phy_low[0] == BASE + 1 && phy_low[2] == BASE + 1, "R1 phy reset length", phy_low[0], BASE + 1);
    chk(start_cyc == core_rise_cyc && starts == 1, "R4 start with core release", start_cyc, core_rise_cyc);
    rd(2, 32'd1, 0, "R11 ctl busy bit during load");
    rd(3, 32'd0, 1, "R7 gated read");
    wr(3, 32'h77);
    wait_ready("R5 ready after load");
    chk(first_tick_cyc - start_cyc == PERB - 1, "R4 first tick", first_tick_cyc - start_cyc, PERB - 1);
    chk(done_cyc - start_cyc == 4 * PERB - 1, "R4 tick spacing", done_cyc - start_cyc, 4 * PERB - 1);
    chk(ready_cyc == done_cyc + 1, "R5 ready one after done", ready_cyc, done_cyc + 1);
    rd(3, 32'd0, 0, "R8 write before ready dropped");
    rd(1, 32'h8000_000A, 0, "R11 cfg ready bit");
    rd(0, PROBE, 0, "R10 probe after base");
    rd(2, 32'd0, 0, "R11 ctl idle");
    wr(3, 32'h1234);
    wr(4, 32'h55);
    rd(3, 32'h1234, 0, "R9 keep written");
    rd(4, 32'h55, 0, "R9 soft written");

    // digital reset
    strap_in = 4'h5;
    ldr_nbytes = 2;
    clr_phy();
    starts0 = starts;
    wr(2, 32'd1);
    chk(!ready && !core_rst_n, "R3 digital reset entered", {30'd0, ready, core_rst_n}, 32'd0);
    wr(2, 32'd1);
    wr(3, 32'h9999);
    while (!core_rst_n) step();
    chk(core_rise_cyc - core_fall_cyc == BASE, "R3 digital length", core_rise_cyc - core_fall_cyc, BASE);
    chk(phy_low[0] + phy_low[1] + phy_low[2] == 0, "R3 phys untouched", phy_low[1], 0);
    wait_ready("R5 ready after digital");
    chk(starts == starts0 + 1, "R8 one sequence only", starts, starts0 + 1);
    chk(ready_cyc == done_cyc + 1, "R5 ready after done digital", ready_cyc, done_cyc + 1);
    rd(3, 32'h1234, 0, "R9 keep survives");
    rd(4, 32'd0, 0, "R9 soft cleared");
    rd(1, 32'h8000_000A, 0, "R2 straps held through digital");

    // single PHY reset
    clr_phy();
    fall0 = core_fall_cyc;
    starts0 = starts;
    wr(2, 32'd4);
    rd(2, 32'd4, 0, "R6 ctl busy bit");
    repeat (10) step();
    chk(phy_low[1] == PHYC, "R6 phy1 length", phy_low[1], PHYC);
    chk(phy_low[0] == 0 && phy_low[2] == 0, "R6 others untouched", phy_low[0] + phy_low[2], 0);
    chk(core_fall_cyc == fall0 && ready && starts == starts0, "R6 core and loader untouched", starts, starts0);
    rd(2, 32'd0, 0, "R6 ctl self clear");
    rd(1, 32'h8000_000A, 0, "R2 straps held through phy reset");

    // empty loader
    ldr_empty = 1'b1;
    starts0 = starts;
    wr(2, 32'd1);
    wait_ready("R5 ready empty loader");
    chk(ready_cyc == core_rise_cyc && starts == starts0, "R5 empty skip load", ready_cyc, core_rise_cyc);

    // second pin reset
    rst_n = 1'b0;
    q_exp.delete(); q_tag.delete();
    repeat (3) step();
    rst_n = 1'b1;
    wait_ready("R1 ready after second pin");
    rd(3, 32'd0, 0, "R9 keep cleared by pin");
    rd(1, 32'h8000_0005, 0, "R2 straps recaptured");
    repeat (3) step();
    chk(q_exp.size() == 0, "R11 all responses seen", q_exp.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule